// File: doc/BRIEF.md
# Multi-Port Memory Request Arbiter

This block decides which of several requesting ports may use a single shared memory unit for its next access cycle. Every port drives a request line, an urgency flag and a reserve flag. In each arbitration cycle at most one port is selected. The selection starts from a fixed order by port position, and the urgency flags and a lock held by one port can override that order. The arbiter registers the chosen port as a one-hot grant. It raises a one-cycle strobe when the grant is issued and keeps a busy level up until the memory signals that the access cycle has finished.

A port that wins while its reserve flag is set takes a lock on the memory. While the lock is held, only that port can be granted, and requests from all other ports wait. The owner releases the lock when it wins again with its reserve flag clear. Storage timing, the data path and parity are handled outside this block.

Top module: `mem_port_arbiter`

## Requirements
- R1: The port count is the parameter NUM_PORTS, which must be 2, 4 or 6. Port i uses bit i of every vector port.
- R2: The grant vector has at most one bit set at any time.
- R3: Among eligible requests that do not have the urgency flag, the lowest-numbered port wins. Port 0 has the highest priority.
- R4: An eligible request with its urgency flag set (hiPriVec bit = 1) wins over every request without the flag, whatever its position. Among several urgent requests, the lowest-numbered port wins.
- R5: An urgency flag or reserve flag on a port whose request line is low has no effect. That port is not granted, and it takes no lock.
- R6: When the arbiter is idle and an eligible request is present at a clock edge, grantVec and busy are high from the following cycle. grantValid is high for that first cycle only. The grant then stays unchanged until cycleDone is sampled high.
- R7: When cycleDone is sampled high while busy, grantVec clears and busy falls in the next cycle. The next arbitration happens at the end of that cycle, so the earliest new grant is visible two cycles after the cycleDone cycle.
- R8: When no eligible request is pending, grantVec is all zeros, and grantValid and busy are low.
- R9: A grant issued to a port whose reserve flag (rsvVec bit = 1) is set takes the lock. While the lock is held, only that port can be granted. Requests from other ports receive no grant, even when they are urgent.
- R10: The lock is released by a later grant to the owning port with its reserve flag clear. After that grant completes, ordinary arbitration resumes.
- R11: A cycleDone pulse while the arbiter is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_PORTS | Request line per port |
| hiPriVec | input | NUM_PORTS | Urgency flag per port |
| rsvVec | input | NUM_PORTS | Reserve flag per port |
| cycleDone | input | 1 | Memory access cycle finished |
| grantVec | output | NUM_PORTS | One-hot grant |
| grantValid | output | 1 | One-cycle strobe when a grant is issued |
| busy | output | 1 | A grant is being held |

## Verification
The assertions assume that cycleDone is asserted only after a grant has been issued. They also assume that each request is sampled in the cycle it is judged, so the port that was granted was requesting in the cycle before grantValid. The bench changes its inputs one time unit after a rising edge and samples one time unit after the next edge. Before it presents a new pattern, it completes each access with a single cycleDone pulse and then clears the request lines. The one exception is the idle-pulse test, which sends cycleDone with no grant outstanding on purpose to exercise R11.

// File: rtl/mem_port_arbiter_pkg.sv
package mem_port_arbiter_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobes_t;

endpackage

// File: rtl/mem_port_arbiter_ctrl.sv
module mem_port_arbiter_ctrl
  import mem_port_arbiter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyEligible,
  input  logic        cycleDone,
  output arbStrobes_t strobes,
  output logic        busy
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes.loadGrant  = 1'b0;
    strobes.clearGrant = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (anyEligible) begin
          strobes.loadGrant = 1'b1;
          stateNext         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cycleDone) begin
          strobes.clearGrant = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_HOLD);

  AST_NO_REARB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cycleDone) |=> !busy); // R7

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyEligible) |=> !busy); // R11

endmodule

// File: rtl/mem_port_arbiter_dp.sv
module mem_port_arbiter_dp
  import mem_port_arbiter_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqVec,
  input  logic [NUM_PORTS-1:0] hiPriVec,
  input  logic [NUM_PORTS-1:0] rsvVec,
  input  arbStrobes_t          strobes,
  output logic                 anyEligible,
  output logic [NUM_PORTS-1:0] grantVec,
  output logic                 grantValid
);

  localparam logic [NUM_PORTS-1:0] ALL_PORTS = {NUM_PORTS{1'b1}};

  logic                 rsvActive;
  logic [NUM_PORTS-1:0] ownerVec;
  logic [NUM_PORTS-1:0] lockMask;
  logic [NUM_PORTS-1:0] eligVec;
  logic [NUM_PORTS-1:0] urgentVec;
  logic [NUM_PORTS-1:0] poolVec;
  logic [NUM_PORTS-1:0] pickVec;
  logic [NUM_PORTS-1:0] lowerSeen;

  assign lockMask    = rsvActive ? ownerVec : ALL_PORTS;
  assign eligVec     = reqVec & lockMask;
  assign urgentVec   = eligVec & hiPriVec;
  assign poolVec     = (|urgentVec) ? urgentVec : eligVec;
  assign anyEligible = |eligVec;

  // lowest-index one-hot pick: bit i wins when no lower bit of the pool is set
  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : gPick
      if (i == 0) begin : gFirst
        assign lowerSeen[i] = 1'b0;
      end else begin : gRest
        assign lowerSeen[i] = lowerSeen[i-1] | poolVec[i-1];
      end
      assign pickVec[i] = poolVec[i] & ~lowerSeen[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec   <= '0;
      grantValid <= 1'b0;
    end else begin
      grantValid <= strobes.loadGrant;
      if (strobes.loadGrant)       grantVec <= pickVec;
      else if (strobes.clearGrant) grantVec <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsvActive <= 1'b0;
      ownerVec  <= '0;
    end else if (strobes.loadGrant) begin
      if (|(pickVec & rsvVec)) begin
        rsvActive <= 1'b1;
        ownerVec  <= pickVec;
      end else if (rsvActive) begin
        rsvActive <= 1'b0;
        ownerVec  <= '0;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R2

  AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((grantVec & $past(reqVec)) != '0)); // R5

  AST_LOCK_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && $past(rsvActive)) |-> (grantVec == $past(ownerVec))); // R9

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0 && !strobes.clearGrant) |=> $stable(grantVec)); // R6

endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import mem_port_arbiter_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqVec,
  input  logic [NUM_PORTS-1:0] hiPriVec,
  input  logic [NUM_PORTS-1:0] rsvVec,
  input  logic                 cycleDone,
  output logic [NUM_PORTS-1:0] grantVec,
  output logic                 grantValid,
  output logic                 busy
);

  arbStrobes_t strobes;
  logic        anyEligible;

  initial begin
    AST_PORT_COUNT: assert (NUM_PORTS == 2 || NUM_PORTS == 4 || NUM_PORTS == 6)
      else $error("NUM_PORTS must be 2, 4 or 6"); // R1
  end

  mem_port_arbiter_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .anyEligible (anyEligible),
    .cycleDone   (cycleDone),
    .strobes     (strobes),
    .busy        (busy)
  );

  mem_port_arbiter_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqVec      (reqVec),
    .hiPriVec    (hiPriVec),
    .rsvVec      (rsvVec),
    .strobes     (strobes),
    .anyEligible (anyEligible),
    .grantVec    (grantVec),
    .grantValid  (grantValid)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (grantVec == '0 && !grantValid)); // R8

endmodule

// File: tb/mem_port_arbiter_bench.sv
module mem_port_arbiter_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic [N-1:0] hiPriVec = '0;
  logic [N-1:0] rsvVec = '0;
  logic         cycleDone = 1'b0;
  logic [N-1:0] grantVec;
  logic         grantValid;
  logic         busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mem_port_arbiter #(.NUM_PORTS(N)) u_mem_port_arbiter (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .hiPriVec(hiPriVec),
    .rsvVec(rsvVec), .cycleDone(cycleDone), .grantVec(grantVec),
    .grantValid(grantValid), .busy(busy)
  );

  task automatic check(input string tag, input logic [N+1:0] act, input logic [N+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {grant,valid,busy}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] h, input logic [N-1:0] s);
    reqVec = r; hiPriVec = h; rsvVec = s;
  endtask

  // present a pattern, expect a grant, hold one cycle, finish with cycleDone
  task automatic grantCycle(input string tag, input logic [N-1:0] r, input logic [N-1:0] h,
                            input logic [N-1:0] s, input logic [N-1:0] expG);
    drive(r, h, s);
    tick;
    check({tag, " issue"}, {grantVec, grantValid, busy}, {expG, 1'b1, 1'b1});
    tick;
    check({tag, " hold R6"}, {grantVec, grantValid, busy}, {expG, 1'b0, 1'b1});
    cycleDone = 1'b1;
    tick;
    cycleDone = 1'b0;
    drive('0, '0, '0);
    check({tag, " release R7"}, {grantVec, grantValid, busy}, {{N{1'b0}}, 1'b0, 1'b0});
    tick;
  endtask

  task automatic testReset;
    check("R8 reset", {grantVec, grantValid, busy}, '0);
  endtask

  task automatic testFixedOrder;
    grantCycle("R3 ports 1,3", 4'b1010, '0, '0, 4'b0010);
    grantCycle("R3 all ports", 4'b1111, '0, '0, 4'b0001);
    grantCycle("R3 single top", 4'b1000, '0, '0, 4'b1000);
  endtask

  task automatic testUrgent;
    grantCycle("R4 urgent 3", 4'b1001, 4'b1000, '0, 4'b1000);
    grantCycle("R4 two urgent", 4'b1111, 4'b1100, '0, 4'b0100);
    grantCycle("R5 urgent idle line", 4'b0100, 4'b0001, '0, 4'b0100);
  endtask

  task automatic testNoRequest;
    drive('0, 4'b1111, 4'b1111);
    tick; tick;
    check("R8 R5 flags only", {grantVec, grantValid, busy}, '0);
    drive('0, '0, '0);
    // a stray rsv flag must not have locked: port 0 still wins
    grantCycle("R5 no lock taken", 4'b0011, '0, '0, 4'b0001);
  endtask

  task automatic testRearbTiming;
    drive(4'b0110, '0, '0);
    tick;
    check("R6 first grant", {grantVec, grantValid, busy}, {4'b0010, 1'b1, 1'b1});
    drive(4'b0101, '0, '0);
    tick;
    check("R6 stable under new reqs", {grantVec, grantValid, busy}, {4'b0010, 1'b0, 1'b1});
    cycleDone = 1'b1;
    tick;
    cycleDone = 1'b0;
    check("R7 gap cycle", {grantVec, grantValid, busy}, {{N{1'b0}}, 1'b0, 1'b0});
    tick;
    check("R7 next grant", {grantVec, grantValid, busy}, {4'b0001, 1'b1, 1'b1});
    cycleDone = 1'b1;
    tick;
    cycleDone = 1'b0;
    drive('0, '0, '0);
    tick;
  endtask

  task automatic testIdleDone;
    cycleDone = 1'b1;
    tick;
    cycleDone = 1'b0;
    check("R11 idle done", {grantVec, grantValid, busy}, '0);
    grantCycle("R11 normal after", 4'b0100, '0, '0, 4'b0100);
  endtask

  task automatic testReservation;
    grantCycle("R9 take lock", 4'b0100, '0, 4'b0100, 4'b0100);
    drive(4'b0011, 4'b0011, '0);
    tick; tick; tick;
    check("R9 others blocked", {grantVec, grantValid, busy}, '0);
    drive('0, '0, '0);
    grantCycle("R9 owner relock", 4'b0111, 4'b0001, 4'b0100, 4'b0100);
    grantCycle("R10 release", 4'b0111, 4'b0001, '0, 4'b0100);
    grantCycle("R10 after release", 4'b0111, '0, '0, 4'b0001);
  endtask

  initial begin
    #1;
    tick; tick;
    testReset;
    rstN = 1'b1;
    tick;
    testReset;
    testFixedOrder;
    testUrgent;
    testNoRequest;
    testRearbTiming;
    testIdleDone;
    testReservation;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule